// File: doc/BRIEF.md
# Calibration retention table controller

This block keeps calibration words for a multi-chain receiver radio. Each chain has its own bank of six entries. Three of them hold DC-offset DAC settings for the loop, low and high paths. One holds a filter calibration, one holds receive gain settings and one holds a peak-detector offset. Each word carries 28 bits.

A host reaches the banks through a small register file. Each chain has its own access register and its own data register. A transfer is set up with the start bit clear and then launched by setting the start bit. The host polls that bit until it drops: a write has then stored the data register into the table, and a read has loaded the addressed entry into the data register.

A global control register holds an enable, a six-bit restore mask and a force bit. Setting the force bit replays the stored words to the radio. The sequencer visits every entry of every bank in turn. It issues one radio write for each entry whose mask bit is set, in a chain whose bit in the chain-enable input is high. When the walk ends, the force bit clears itself.

Top module: `cal_retain_ctrl`

## Requirements
- R1: After reset every register reads 0, every table entry holds 0 and `radio_valid` is low.
- R2: Register addresses and fields:
  - Addresses:
    - Address 0 is the control register.
    - Address 1+2c is the access register of chain c.
    - Address 2+2c is the data register of chain c.
  - Control register fields: bit 0 is enable, bit 1 is force and bits 13:8 are the restore mask.
  - Access register fields: bit 0 is start/busy, bit 1 is write and bits 6:4 are the entry index.
  - The data register keeps bits 27:0 of what is written and reads 0 above them.
- R3: A start write (bit 0 set, while busy is 0) makes busy read 1 for exactly 2 cycles and then 0. A transfer with write=1 then holds the data register value in the addressed entry.
- R4: After a transfer with write=0 completes, the data register holds the addressed entry. For index 6 or 7, a read returns 0 and a write changes no entry.
- R5: A write to an access register while its busy bit is 1 is ignored: its index and write fields keep their values.
- R6: A write to the control register is accepted only while force reads 0. While force reads 1, control writes change nothing.
- R7: An accepted force with enable=1 visits slot (c,i) in the cycle k=6c+i after the accepted write, for k from 0 to 6*NUM_CHAINS-1.
  - In that cycle `radio_valid` is high exactly when mask bit i and `chain_en[c]` are both 1.
  - When it is high, `radio_chain`=c, `radio_index`=i and `radio_data` equals the stored entry.
  - Force reads 1 in all those cycles and reads 0 after them.
- R8: An accepted force with enable=0 makes force read 1 for one cycle and then 0, with no radio write.
- R9: A host transfer that is pending while the restore walk runs does not advance. Its busy bit still reads 1 in the first cycle with force at 0 and in the next cycle, and it clears one cycle later.
- R10: Mask value 0x10 replays only entry 4 of each enabled chain. Mask value 0x30 replays entries 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | ADDR_W (3) | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| chain_en | input | NUM_CHAINS (3) | Chains the restore walk may write |
| radio_valid | output | 1 | Radio write strobe |
| radio_chain | output | CH_W (2) | Chain of the radio write |
| radio_index | output | 3 | Entry index of the radio write |
| radio_data | output | DATA_W (28) | Calibration word of the radio write |

## Verification
The bench builds the block with its defaults: three chains, 28-bit words and a 2-cycle access latency. This gives an 18-cycle restore walk. The third chain is reachable, so chain-enable masks can skip a middle or a final bank. The short latency lets the bench start a transfer in the middle of a walk and watch it freeze until the walk ends. Random transfers also reach the unused indices 6 and 7.

// File: rtl/cal_retain_pkg.sv
package cal_retain_pkg;
  // Entries per bank; mask bit positions map one to one onto these indices.
  localparam int N_ENTRY = 6;
  localparam int IDX_W   = 3;

  // Control register fields
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FORCE_BIT = 1;
  localparam int CTRL_MASK_LSB = 8;

  // Access register fields
  localparam int ACC_GO_BIT  = 0;
  localparam int ACC_WR_BIT  = 1;
  localparam int ACC_IDX_LSB = 4;

  typedef enum logic {SEQ_IDLE, SEQ_WALK} seq_state_e;
endpackage

// File: rtl/cal_bank.sv
module cal_bank
  import cal_retain_pkg::*;
#(
  parameter int DATA_W  = 28,
  parameter int ACC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_we,
  input  logic              data_we,
  input  logic              stall,
  input  logic [31:0]       wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [31:0]       acc_reg,
  output logic [31:0]       data_reg
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

  logic                            go_q, go_d;
  logic                            wr_q, wr_d;
  logic [IDX_W-1:0]                idx_q, idx_d;
  logic [CNT_W-1:0]                cnt_q, cnt_d;
  logic [DATA_W-1:0]               data_q, data_d;
  logic [N_ENTRY-1:0][DATA_W-1:0]  tbl_q, tbl_d;
  logic                            upd_en;
  logic                            idx_ok;

  assign idx_ok = (32'(idx_q) < N_ENTRY);
  assign upd_en = acc_we | data_we | go_q;

  always_comb begin
    go_d   = go_q;
    wr_d   = wr_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    tbl_d  = tbl_q;
    if (data_we) data_d = wdata[DATA_W-1:0];
    if (acc_we && !go_q) begin
      wr_d  = wdata[ACC_WR_BIT];
      idx_d = wdata[ACC_IDX_LSB +: IDX_W];
      if (wdata[ACC_GO_BIT]) begin
        go_d  = 1'b1;
        cnt_d = CNT_W'(ACC_LAT - 1);
      end
    end else if (go_q && !stall) begin
      if (cnt_q == '0) begin
        go_d = 1'b0;
        if (wr_q) begin
          if (idx_ok) tbl_d[idx_q] = data_q;
        end else begin
          data_d = idx_ok ? tbl_q[idx_q] : '0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      tbl_q  <= '0;
    end else if (upd_en) begin
      go_q   <= go_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      tbl_q  <= tbl_d;
    end
  end

  always_comb begin
    acc_reg = '0;
    acc_reg[ACC_GO_BIT] = go_q;
    acc_reg[ACC_WR_BIT] = wr_q;
    acc_reg[ACC_IDX_LSB +: IDX_W] = idx_q;
  end

  assign data_reg = 32'(data_q);
  assign rd_word  = (32'(rd_idx) < N_ENTRY) ? tbl_q[rd_idx] : '0;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && stall) |=> go_q);

  // R5
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && acc_we) |=> ($stable(idx_q) && $stable(wr_q)));
endmodule

// File: rtl/cal_restore_seq.sv
module cal_restore_seq
  import cal_retain_pkg::*;
#(
  parameter int NUM_CHAINS = 3,
  parameter int CH_W       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [31:0]        wdata,
  output logic               en_q,
  output logic [N_ENTRY-1:0] mask_q,
  output logic               force_q,
  output logic               walk,
  output logic [CH_W-1:0]    ch_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic [31:0]        ctrl_reg
);
  seq_state_e         state_q, state_d;
  logic               en_d, force_d;
  logic [N_ENTRY-1:0] mask_d;
  logic [CH_W-1:0]    ch_d;
  logic [IDX_W-1:0]   idx_d;
  logic               accept, last_slot, upd_en;

  assign accept    = ctrl_we && !force_q;
  assign walk      = (state_q == SEQ_WALK);
  assign last_slot = (ch_q == CH_W'(NUM_CHAINS - 1)) && (idx_q == IDX_W'(N_ENTRY - 1));
  assign upd_en    = ctrl_we | force_q;

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    mask_d  = mask_q;
    force_d = force_q;
    ch_d    = ch_q;
    idx_d   = idx_q;
    if (accept) begin
      en_d   = wdata[CTRL_EN_BIT];
      mask_d = wdata[CTRL_MASK_LSB +: N_ENTRY];
      if (wdata[CTRL_FORCE_BIT]) begin
        force_d = 1'b1;
        state_d = wdata[CTRL_EN_BIT] ? SEQ_WALK : SEQ_IDLE;
        ch_d    = '0;
        idx_d   = '0;
      end
    end else if (walk) begin
      if (last_slot) begin
        state_d = SEQ_IDLE;
        force_d = 1'b0;
      end else if (idx_q == IDX_W'(N_ENTRY - 1)) begin
        idx_d = '0;
        ch_d  = ch_q + 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (force_q) begin
      force_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      en_q    <= 1'b0;
      mask_q  <= '0;
      force_q <= 1'b0;
      ch_q    <= '0;
      idx_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      en_q    <= en_d;
      mask_q  <= mask_d;
      force_q <= force_d;
      ch_q    <= ch_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    ctrl_reg = '0;
    ctrl_reg[CTRL_EN_BIT]    = en_q;
    ctrl_reg[CTRL_FORCE_BIT] = force_q;
    ctrl_reg[CTRL_MASK_LSB +: N_ENTRY] = mask_q;
  end

  // R7
  walk_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk |-> force_q);

  // R6
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && ctrl_we) |=> ($stable(mask_q) && $stable(en_q)));

  // R8
  idle_force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && !walk) |=> !force_q);
endmodule

// File: rtl/cal_retain_ctrl.sv
module cal_retain_ctrl
  import cal_retain_pkg::*;
#(
  parameter int NUM_CHAINS = 3,
  parameter int DATA_W     = 28,
  parameter int ACC_LAT    = 2,
  localparam int ADDR_W    = $clog2(2 * NUM_CHAINS + 1),
  localparam int CH_W      = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  input  logic [NUM_CHAINS-1:0] chain_en,
  output logic                  radio_valid,
  output logic [CH_W-1:0]       radio_chain,
  output logic [IDX_W-1:0]      radio_index,
  output logic [DATA_W-1:0]     radio_data
);
  logic               en_q, force_q, walk;
  logic [N_ENTRY-1:0] mask_q;
  logic [CH_W-1:0]    ch_q;
  logic [IDX_W-1:0]   idx_q;
  logic [31:0]        ctrl_reg;
  logic               ctrl_we;

  logic [DATA_W-1:0]  words    [NUM_CHAINS];
  logic [31:0]        acc_regs [NUM_CHAINS];
  logic [31:0]        data_regs[NUM_CHAINS];

  assign ctrl_we = host_we && (host_addr == '0);

  cal_restore_seq #(.NUM_CHAINS(NUM_CHAINS), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wdata(host_wdata),
    .en_q(en_q), .mask_q(mask_q), .force_q(force_q), .walk(walk),
    .ch_q(ch_q), .idx_q(idx_q), .ctrl_reg(ctrl_reg)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_bank
    logic acc_we_c, data_we_c;
    assign acc_we_c  = host_we && (host_addr == ADDR_W'(2 * c + 1));
    assign data_we_c = host_we && (host_addr == ADDR_W'(2 * c + 2));
    cal_bank #(.DATA_W(DATA_W), .ACC_LAT(ACC_LAT)) u_bank (
      .clk(clk), .rst_n(rst_n), .acc_we(acc_we_c), .data_we(data_we_c),
      .stall(walk), .wdata(host_wdata), .rd_idx(idx_q), .rd_word(words[c]),
      .acc_reg(acc_regs[c]), .data_reg(data_regs[c])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == '0) host_rdata = ctrl_reg;
    for (int c = 0; c < NUM_CHAINS; c++) begin
      if (host_addr == ADDR_W'(2 * c + 1)) host_rdata = acc_regs[c];
      if (host_addr == ADDR_W'(2 * c + 2)) host_rdata = data_regs[c];
    end
  end

  assign radio_valid = walk && mask_q[idx_q] && chain_en[ch_q];
  assign radio_chain = ch_q;
  assign radio_index = idx_q;
  assign radio_data  = words[ch_q];

  // R7
  radio_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    radio_valid |-> (force_q && en_q));

  // R10
  radio_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    radio_valid |-> (32'(radio_index) < N_ENTRY));
endmodule

// File: tb/test_cal_retain_ctrl.sv
module test_cal_retain_ctrl;
  localparam int NC = 3;
  localparam int DW = 28;

  logic        clk, rst_n, host_we;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [NC-1:0] chain_en;
  logic        radio_valid;
  logic [1:0]  radio_chain;
  logic [2:0]  radio_index;
  logic [DW-1:0] radio_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] model [NC][8];

  cal_retain_ctrl i_cal_retain_ctrl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .chain_en(chain_en),
    .radio_valid(radio_valid), .radio_chain(radio_chain),
    .radio_index(radio_index), .radio_data(radio_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic reg_wr(input int addr, input logic [31:0] d);
    host_we = 1'b1; host_addr = 3'(addr); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic reg_rd(input int addr, output logic [31:0] d);
    host_addr = 3'(addr);
    #1;
    d = host_rdata;
  endtask

  function automatic logic [31:0] acc_word(input int idx, input bit wr, input bit go);
    return (32'(idx) << 4) | (32'(wr) << 1) | 32'(go);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit en, input bit frc, input logic [5:0] m);
    return (32'(m) << 8) | (32'(frc) << 1) | 32'(en);
  endfunction

  task automatic host_access(input int ch, input int idx, input bit wr, input logic [DW-1:0] d);
    logic [31:0] r;
    if (wr) reg_wr(2 * ch + 2, 32'(d));
    reg_wr(2 * ch + 1, acc_word(idx, wr, 0));
    reg_wr(2 * ch + 1, acc_word(idx, wr, 1));
    reg_rd(2 * ch + 1, r); chk(r & 1, 1, "R3 busy cycle 1");
    @(negedge clk);
    reg_rd(2 * ch + 1, r); chk(r & 1, 1, "R3 busy cycle 2");
    @(negedge clk);
    reg_rd(2 * ch + 1, r); chk(r & 1, 0, "R3 busy cleared");
    if (wr) begin
      if (idx < 6) model[ch][idx] = d;
    end else begin
      reg_rd(2 * ch + 2, r);
      chk(r, (idx < 6) ? 32'(model[ch][idx]) : 32'h0, "R4 read data");
    end
  endtask

  task automatic do_restore(input bit en, input logic [5:0] m, input logic [NC-1:0] cen);
    logic [31:0] r;
    chain_en = cen;
    reg_wr(0, ctrl_word(en, 1, m));
    if (en) begin
      for (int k = 0; k < NC * 6; k++) begin
        int c, i;
        bit ev;
        c = k / 6; i = k % 6;
        ev = m[i] & cen[c];
        reg_rd(0, r); chk((r >> 1) & 1, 1, "R7 force held during walk");
        chk(32'(radio_valid), 32'(ev), "R7/R10 radio_valid");
        if (ev) begin
          chk(32'(radio_chain), 32'(c), "R7 radio_chain");
          chk(32'(radio_index), 32'(i), "R7 radio_index");
          chk(32'(radio_data), 32'(model[c][i]), "R7 radio_data");
        end
        @(negedge clk);
      end
      reg_rd(0, r); chk(r, ctrl_word(en, 0, m), "R7 force cleared after walk");
    end else begin
      reg_rd(0, r); chk((r >> 1) & 1, 1, "R8 force one cycle");
      chk(32'(radio_valid), 0, "R8 no radio write");
      @(negedge clk);
      reg_rd(0, r); chk((r >> 1) & 1, 0, "R8 force cleared");
      chk(32'(radio_valid), 0, "R8 no radio write after");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    host_we = 0; host_addr = 0; host_wdata = 0; chain_en = '1;
    for (int c = 0; c < NC; c++) for (int i = 0; i < 8; i++) model[c][i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 2 * NC + 1; a++) begin
      reg_rd(a, r); chk(r, 0, "R1 register reset value");
    end
    chk(32'(radio_valid), 0, "R1 radio_valid idle");
    host_access(2, 5, 0, '0);

    // R2 data register width
    reg_wr(2, 32'hFFFF_FFFF);
    reg_rd(2, r); chk(r, 32'h0FFF_FFFF, "R2 data register bits");
    reg_wr(2, 32'h0);

    // R3/R4 directed
    host_access(0, 0, 1, 28'hABC_DEF1);
    host_access(0, 0, 0, '0);
    host_access(1, 6, 1, 28'h123_4567);
    host_access(1, 6, 0, '0);
    host_access(1, 7, 0, '0);

    // R5 busy write ignored
    reg_wr(2, 32'h0555_0001);
    reg_wr(1, acc_word(1, 1, 0));
    reg_wr(1, acc_word(1, 1, 1));
    reg_wr(1, acc_word(3, 0, 1));
    reg_rd(1, r); chk(r, acc_word(1, 1, 1), "R5 busy write ignored");
    @(negedge clk);
    reg_rd(1, r); chk(r, acc_word(1, 1, 0), "R5 transfer finished");
    model[0][1] = 28'h555_0001;
    host_access(0, 1, 0, '0);

    // random transfers
    for (int n = 0; n < 40; n++) begin
      int ch, idx;
      bit wr;
      ch = int'($urandom % NC); idx = int'($urandom % 8); wr = 1'($urandom);
      host_access(ch, idx, wr, DW'($urandom));
    end
    for (int c = 0; c < NC; c++) for (int i = 0; i < 6; i++)
      if (($urandom % 2) == 0) host_access(c, i, 1, DW'($urandom));

    // R10 directed masks, R7 chain skipping
    do_restore(1, 6'h10, 3'b111);
    do_restore(1, 6'h30, 3'b101);
    do_restore(1, 6'h30, 3'b010);
    // R8 disabled restore
    do_restore(0, 6'h3F, 3'b111);
    // random restores
    for (int n = 0; n < 4; n++) do_restore(1, 6'($urandom), NC'($urandom));

    // R6 and R9: control lock and stalled transfer during walk
    chain_en = '1;
    reg_wr(0, ctrl_word(1, 1, 6'h30));
    reg_wr(0, ctrl_word(1, 1, 6'h10));
    reg_rd(0, r); chk(r, ctrl_word(1, 1, 6'h30), "R6 control write ignored while force");
    reg_wr(4, 32'h0777_7777);
    reg_wr(3, acc_word(2, 1, 0));
    reg_wr(3, acc_word(2, 1, 1));
    for (int t = 0; t < 40; t++) begin
      reg_rd(0, r);
      if (((r >> 1) & 1) == 0) break;
      @(negedge clk);
    end
    reg_rd(0, r); chk((r >> 1) & 1, 0, "R9 walk ended");
    reg_rd(3, r); chk(r & 1, 1, "R9 busy held at walk end");
    @(negedge clk);
    reg_rd(3, r); chk(r & 1, 1, "R9 busy one cycle after");
    @(negedge clk);
    reg_rd(3, r); chk(r & 1, 0, "R9 busy cleared");
    model[1][2] = 28'h777_7777;
    host_access(1, 2, 0, '0);
    reg_wr(0, ctrl_word(1, 0, 6'h10));
    reg_rd(0, r); chk(r, ctrl_word(1, 0, 6'h10), "R6 control write accepted when idle");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule